// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This unit sits between the operand-address logic and the memory bus. Each cycle it may receive a 17-bit logical effective address with a valid strobe and a user/monitor flag. It returns either a physical address, a protection-violation trap, or a nonexistent-memory indication, always one clock after the request.

In user mode the logical address is checked against a limit held as a count of 256-word chunks. If it is in bounds, it is offset by a relocation base held as a chunk number. The relocated address is then checked against the installed memory size. In monitor mode the address passes through untranslated. A monitor access to missing memory hangs the unit until reset, which models a bus cycle that never completes.

The base and limit registers are loaded through dedicated write strobes. A small controller has two states. In `ST_RUN` requests are served. In `ST_HUNG` the stall is held and requests are dropped. The only transition, `RUN_TO_HUNG`, is taken on a monitor-mode access to nonexistent memory. Reset returns the controller to `ST_RUN`.

Top module: `reloc_guard`

## Requirements
- R1: After reset, `pa_vld`, `viol_trap`, `nxm_trap` and `nxm_stall` are low, and both the base and limit registers read as zero in their effect: a user access to chunk 0 traps as a violation.
- R2: `base_wr` loads `base_din` and `limit_wr` loads `limit_din` at a clock edge. The new values govern every access presented in later cycles.
- R3: In user mode, a request whose chunk number `ea[16:8]` is greater than or equal to the limit produces a one-cycle `viol_trap` one clock after `ea_vld`, with `pa_vld` low.
- R4: In user mode, an in-bounds request produces `pa_vld` high for one cycle, one clock after `ea_vld`, with `pa = (ea + base*256) mod 2^17`. This holds provided the relocated chunk `pa[16:8]` is below `mem_chunks`.
- R5: In user mode, an in-bounds request whose relocated chunk is greater than or equal to `mem_chunks` produces a one-cycle `nxm_trap` one clock later, with `pa_vld` and `viol_trap` low.
- R6: In monitor mode, `pa` equals `ea` unchanged and the limit and base have no effect. `pa_vld` is raised one clock after `ea_vld` when `ea[16:8] < mem_chunks`.
- R7: In monitor mode, a request with `ea[16:8] >= mem_chunks` raises `nxm_stall` one clock later. The stall stays high, and no later request yields `pa_vld` or a trap, until reset.
- R8: In a cycle after one with `ea_vld` low, `pa_vld`, `viol_trap` and `nxm_trap` are all low.
- R9: In user mode, the auto-increment cells at logical addresses 8 to 15 relocate to `base*256+8` through `base*256+15`.
- R10: A limit of zero makes every user-mode request a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Load strobe for the relocation base |
| base_din | input | 9 | Relocation base as a chunk number |
| limit_wr | input | 1 | Load strobe for the limit |
| limit_din | input | 10 | Program size in 256-word chunks |
| mem_chunks | input | 10 | Installed memory in 256-word chunks |
| ea_vld | input | 1 | Effective address request strobe |
| ea | input | 17 | Logical effective address |
| user_mode | input | 1 | 1 = user (translated), 0 = monitor |
| pa_vld | output | 1 | Physical address valid pulse |
| pa | output | 17 | Physical address |
| viol_trap | output | 1 | Limit violation trap pulse |
| nxm_trap | output | 1 | User nonexistent-memory trap pulse |
| nxm_stall | output | 1 | Monitor nonexistent-memory hang (sticky) |

## Verification
Random requests mix both modes, random bases, limits of 0 to 512 chunks and memory sizes of 256 to 512 chunks. Half of the user addresses are drawn inside the limit so that the in-bounds and trap outcomes appear in comparable numbers. Directed cases probe the exact limit edge (chunk equal to limit versus limit minus one), sums that wrap past 17 bits, and auto-increment cells under a non-zero base. A zero limit separates the violation path from the nonexistent-memory path. Monitor accesses just below and at the memory size expose the sticky hang, and a request issued while hung must stay silent.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    parameter int ADDR_W  = 17;
    parameter int CHUNK_W = 8;
    localparam int PAGE_W = ADDR_W - CHUNK_W;
    localparam int CNT_W  = PAGE_W + 1;

    typedef enum logic [2:0] {
        DEC_NONE,
        DEC_PASS,
        DEC_VIOL,
        DEC_NXM,
        DEC_HANG
    } dec_t;

    typedef enum logic {
        ST_RUN,
        ST_HUNG
    } st_t;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [PAGE_W-1:0] base_din,
    input  logic              limit_wr,
    input  logic [CNT_W-1:0]  limit_din,
    output logic [PAGE_W-1:0] base_q,
    output logic [CNT_W-1:0]  limit_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else begin
            if (base_wr)  base_q  <= base_din;
            if (limit_wr) limit_q <= limit_din;
        end
    end

    p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> base_q == $past(base_din));
    p_load_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        limit_wr |=> limit_q == $past(limit_din));
endmodule

// File: rtl/reloc_check.sv
module reloc_check
    import reloc_pkg::*;
(
    input  logic              ea_vld,
    input  logic [ADDR_W-1:0] ea,
    input  logic              user_mode,
    input  logic [PAGE_W-1:0] base_q,
    input  logic [CNT_W-1:0]  limit_q,
    input  logic [CNT_W-1:0]  mem_chunks,
    output dec_t              dec,
    output logic [ADDR_W-1:0] phys
);
    logic [PAGE_W-1:0] log_chunk;
    logic [ADDR_W-1:0] reloc_sum;
    logic              over_limit;
    logic              missing_user;
    logic              missing_mon;

    always_comb begin
        log_chunk    = ea[ADDR_W-1:CHUNK_W];
        over_limit   = {1'b0, log_chunk} >= limit_q;
        reloc_sum    = ea + {base_q, {CHUNK_W{1'b0}}};
        missing_user = {1'b0, reloc_sum[ADDR_W-1:CHUNK_W]} >= mem_chunks;
        missing_mon  = {1'b0, log_chunk} >= mem_chunks;
        phys         = user_mode ? reloc_sum : ea;
        if (!ea_vld)
            dec = DEC_NONE;
        else if (user_mode) begin
            if (over_limit)        dec = DEC_VIOL;
            else if (missing_user) dec = DEC_NXM;
            else                   dec = DEC_PASS;
        end else begin
            if (missing_mon)       dec = DEC_HANG;
            else                   dec = DEC_PASS;
        end
    end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [8:0]        base_din,
    input  logic              limit_wr,
    input  logic [9:0]        limit_din,
    input  logic [9:0]        mem_chunks,
    input  logic              ea_vld,
    input  logic [16:0]       ea,
    input  logic              user_mode,
    output logic              pa_vld,
    output logic [16:0]       pa,
    output logic              viol_trap,
    output logic              nxm_trap,
    output logic              nxm_stall
);
    logic [PAGE_W-1:0] base_q;
    logic [CNT_W-1:0]  limit_q;
    dec_t              dec;
    logic [ADDR_W-1:0] phys;
    st_t               state, state_nx;

    reloc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .base_wr(base_wr), .base_din(base_din),
        .limit_wr(limit_wr), .limit_din(limit_din),
        .base_q(base_q), .limit_q(limit_q)
    );

    reloc_check u_check (
        .ea_vld(ea_vld), .ea(ea), .user_mode(user_mode),
        .base_q(base_q), .limit_q(limit_q), .mem_chunks(mem_chunks),
        .dec(dec), .phys(phys)
    );

    // Next-state: RUN_TO_HUNG on a monitor access to missing memory.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (dec == DEC_HANG) state_nx = ST_HUNG;
            ST_HUNG: state_nx = ST_HUNG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_vld    <= 1'b0;
            pa        <= '0;
            viol_trap <= 1'b0;
            nxm_trap  <= 1'b0;
            nxm_stall <= 1'b0;
        end else begin
            pa_vld    <= 1'b0;
            viol_trap <= 1'b0;
            nxm_trap  <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (dec == DEC_PASS) begin
                        pa_vld <= 1'b1;
                        pa     <= phys;
                    end
                    viol_trap <= (dec == DEC_VIOL);
                    nxm_trap  <= (dec == DEC_NXM);
                    nxm_stall <= (dec == DEC_HANG);
                end
                ST_HUNG: nxm_stall <= 1'b1;
            endcase
        end
    end

    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pa_vld, viol_trap, nxm_trap}) <= 1);
    p_stall_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nxm_stall |=> nxm_stall);
    p_silent_hung_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nxm_stall |-> !pa_vld && !viol_trap && !nxm_trap);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_vld && !nxm_stall |=> !pa_vld && !viol_trap && !nxm_trap);
    p_monitor_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ea_vld && !user_mode && !nxm_stall && ({1'b0, ea[16:8]} < mem_chunks)
        |=> pa_vld && pa == $past(ea));
    p_zero_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ea_vld && user_mode && !nxm_stall && limit_q == '0 |=> viol_trap);
endmodule

// File: tb/reloc_guard_bench.sv
module reloc_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        base_wr = 0, limit_wr = 0, ea_vld = 0, user_mode = 0;
    logic [8:0]  base_din = 0;
    logic [9:0]  limit_din = 0, mem_chunks = 10'd512;
    logic [16:0] ea = 0;
    logic        pa_vld, viol_trap, nxm_trap, nxm_stall;
    logic [16:0] pa;

    int n_tests = 0, n_fail = 0;
    logic [8:0] m_base;
    logic [9:0] m_limit;
    bit         m_hung;

    always #(CLK_PERIOD/2) clk = ~clk;

    reloc_guard u_reloc_guard (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_din(base_din),
        .limit_wr(limit_wr), .limit_din(limit_din), .mem_chunks(mem_chunks),
        .ea_vld(ea_vld), .ea(ea), .user_mode(user_mode),
        .pa_vld(pa_vld), .pa(pa), .viol_trap(viol_trap),
        .nxm_trap(nxm_trap), .nxm_stall(nxm_stall)
    );

    // Expected outputs packed as {pa_vld, viol, nxm, stall, pa}
    function automatic logic [20:0] model(input logic um, input logic [16:0] a,
                                          input logic [8:0] b, input logic [9:0] lim,
                                          input logic [9:0] mem, input bit hung);
        logic [16:0] s;
        if (hung) return {4'b0001, 17'd0};
        if (um) begin
            if ({1'b0, a[16:8]} >= lim) return {4'b0100, 17'd0};
            s = a + {b, 8'd0};
            if ({1'b0, s[16:8]} >= mem) return {4'b0010, 17'd0};
            return {4'b1000, s};
        end
        if ({1'b0, a[16:8]} >= mem) return {4'b0001, 17'd0};
        return {4'b1000, a};
    endfunction

    task automatic check(input string req, input logic [20:0] exp);
        logic [20:0] act;
        act = {pa_vld, viol_trap, nxm_trap, nxm_stall, exp[20] ? pa : 17'd0};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; ea_vld = 0; base_wr = 0; limit_wr = 0;
        @(negedge clk); rst_n = 1;
        m_base = 0; m_limit = 0; m_hung = 0;
    endtask

    task automatic load(input logic [8:0] b, input logic [9:0] l);
        @(negedge clk); base_wr = 1; base_din = b; limit_wr = 1; limit_din = l;
        @(negedge clk); base_wr = 0; limit_wr = 0;
        m_base = b; m_limit = l;
    endtask

    task automatic access(input string req, input logic um, input logic [16:0] a);
        logic [20:0] exp;
        @(negedge clk); ea_vld = 1; user_mode = um; ea = a;
        exp = model(um, a, m_base, m_limit, mem_chunks, m_hung);
        @(negedge clk); ea_vld = 0;
        check(req, exp);
        if (exp[17]) m_hung = 1;
        @(negedge clk);
        check("R8", m_hung ? {4'b0001, 17'd0} : 21'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        check("R1", 21'd0);
        access("R1", 1'b1, 17'h00005);
        // R10: zero limit traps everything in user mode
        access("R10", 1'b1, 17'h1FFFF);
        load(9'd128, 10'd96);
        access("R4", 1'b1, 17'h05F00 + 17'hFF);
        access("R3", 1'b1, 17'h06000);
        access("R9", 1'b1, 17'o10);
        access("R9", 1'b1, 17'o17);
        access("R6", 1'b0, 17'h06000);
        // wrap past 17 bits
        load(9'd500, 10'd512);
        access("R4", 1'b1, 17'h01234);
        mem_chunks = 10'd200;
        access("R5", 1'b1, 17'h10000);
        access("R2", 1'b1, 17'h0C7FF);
        load(9'd3, 10'd10);
        access("R2", 1'b1, 17'h00900);
        access("R6", 1'b0, 17'h0C7FF);
        access("R7", 1'b0, 17'h0C800);
        access("R7", 1'b1, 17'h00000);
        do_reset();
        access("R1", 1'b0, 17'h00010);
        for (int i = 0; i < 400; i++) begin
            logic [16:0] a;
            logic        um;
            if (m_hung || ($urandom % 8) == 0) begin
                mem_chunks = 10'(256 + $urandom % 257);
                do_reset();
                load(9'($urandom), 10'($urandom % 513));
            end
            um = ($urandom % 4) != 0;
            a = 17'($urandom);
            if (um && m_limit != 0 && $urandom % 2)
                a = {9'($urandom % m_limit), a[7:0]};
            access(um ? "R4" : "R6", um, a);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule